// File: doc/BRIEF.md
# Circular-Buffer Bit Grouping and Selection

This block takes five interleaved subblocks of a tail-biting convolutional codeword, each `L` bits long, and forms one 60-bit coded block from them. It joins the subblocks in the order first, second, third, fourth, fifth. This gives a grouped sequence `d` of 5L bits. It then reads only a leading window of that sequence, of length `Kbuf`, again and again until 60 bits have been sent. The window length is a stepwise function of `L` and is chosen inside the block. Because of this, short payloads are repeated from a shortened buffer rather than from all 5L bits.

A one-cycle `start` pulse captures the five subblock ports and `payload_len`. Output is serial, one bit per clock, flagged by `bit_valid`. A one-cycle `blk_done` follows the last bit. A length outside 7..24 gives a one-cycle `len_err` and no output at all. The read position runs through a pointer that returns to zero at `Kbuf`, so the block needs no divider.

The controller has four states:
- `ST_IDLE` waits for `start`.
- `ST_EMIT` sends the bits.
- `ST_FINISH` raises `blk_done`.
- `ST_REJECT` raises `len_err`.

Its transitions are:
- IDLE→EMIT on `start` with a legal length.
- IDLE→REJECT on `start` with an illegal length.
- EMIT→EMIT while fewer than 60 bits have been sent.
- EMIT→FINISH on the 60th bit.
- FINISH→IDLE, unconditionally.
- REJECT→IDLE, unconditionally.

Top module: `cbuf_select`

## Requirements
- R1: Grouped bit d_k, for k < 5L, is bit (k mod L) of subblock port number floor(k/L). The ports are numbered 0 to 4 as `sub_a`, `sub_b`, `sub_c`, `sub_d`, `sub_e`, and bit i of a port is its i-th interleaved bit.
- R2: The j-th valid output bit (j from 0 to 59) equals d_(j mod Kbuf).
- R3: After a `start` with a legal length, `bit_valid` is high for exactly 60 consecutive cycles, beginning in the cycle after the sampling edge.
- R4: Kbuf is 30 when L is 7, 8 or 9.
- R5: Kbuf is 50 when L is 10 and 55 when L is 11.
- R6: Kbuf is 60 when L is from 12 to 24, and Kbuf never exceeds 5L.
- R7: `blk_done` is high for exactly one cycle, in the cycle right after the 60th valid bit. `bit_valid` is low in that cycle.
- R8: A `start` with L below 7 or above 24 raises `len_err` for exactly the next cycle. It produces no `bit_valid` and no `blk_done`.
- R9: While a block is being sent, `start` is ignored, and so are changes on the subblock and length inputs. The block keeps the values captured at acceptance.
- R10: After reset, `bit_valid`, `blk_done`, `len_err` and `bit_out` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accept request, sampled in idle |
| payload_len | input | 5 | Payload length L |
| sub_a | input | 24 | First interleaved subblock, bit 0 first |
| sub_b | input | 24 | Second interleaved subblock |
| sub_c | input | 24 | Third interleaved subblock |
| sub_d | input | 24 | Fourth interleaved subblock |
| sub_e | input | 24 | Fifth interleaved subblock |
| bit_out | output | 1 | Serial coded bit |
| bit_valid | output | 1 | `bit_out` carries a coded bit |
| blk_done | output | 1 | One-cycle pulse after the last bit |
| len_err | output | 1 | One-cycle pulse for an illegal length |

## Verification
A subblock or position counter that is off by one at a subblock boundary shows as a wrong `bit_out` at output index L, 2L and so on. This is visible within the first 25 output bits for any legal L. A wrong buffer size or a wrap that happens too late or too early shows at output index Kbuf. That falls inside the block for the short lengths, and the bench checks every bit for lengths that cover each Kbuf step. An output counter that is wrong moves `blk_done` away from the cycle 61 cycles after acceptance, so it shows within one block.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;
    localparam int GRP_CNT = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EMIT,
        ST_FINISH,
        ST_REJECT
    } sel_state_t;
endpackage

// File: rtl/kbuf_lut.sv
module kbuf_lut #(
    parameter int LEN_W    = 5,
    parameter int PTR_W    = 6,
    parameter int MIN_LEN  = 7,
    parameter int MAX_LEN  = 24,
    parameter int SHORT_HI = 9,
    parameter int KB_SHORT = 30,
    parameter int MID_LO   = 10,
    parameter int KB_MID_LO = 50,
    parameter int MID_HI   = 11,
    parameter int KB_MID_HI = 55,
    parameter int KB_LONG  = 60
) (
    input  logic [LEN_W-1:0] len,
    output logic [PTR_W-1:0] kbuf,
    output logic             len_ok
);
    always_comb begin
        len_ok = (int'(len) >= MIN_LEN) && (int'(len) <= MAX_LEN);
        if (int'(len) <= SHORT_HI)
            kbuf = PTR_W'(KB_SHORT);
        else if (int'(len) == MID_LO)
            kbuf = PTR_W'(KB_MID_LO);
        else if (int'(len) == MID_HI)
            kbuf = PTR_W'(KB_MID_HI);
        else
            kbuf = PTR_W'(KB_LONG);
    end
endmodule

// File: rtl/grp_addr.sv
module grp_addr #(
    parameter int LEN_W = 5,
    parameter int PTR_W = 6,
    parameter int SUB_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             adv,
    input  logic [LEN_W-1:0] len,
    input  logic [PTR_W-1:0] kbuf,
    output logic [SUB_W-1:0] sub,
    output logic [LEN_W-1:0] pos,
    output logic [PTR_W-1:0] ptr
);
    import cbuf_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub <= '0;
            pos <= '0;
            ptr <= '0;
        end else if (clear) begin
            sub <= '0;
            pos <= '0;
            ptr <= '0;
        end else if (adv) begin
            if (ptr == kbuf - 1'b1) begin
                sub <= '0;
                pos <= '0;
                ptr <= '0;
            end else begin
                ptr <= ptr + 1'b1;
                if (pos == len - 1'b1) begin
                    pos <= '0;
                    sub <= sub + 1'b1;
                end else begin
                    pos <= pos + 1'b1;
                end
            end
        end
    end

    // R2: read pointer stays inside the truncated buffer
    p_ptr_in_buf_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (ptr < kbuf));

    // R1: subblock selector never walks past the fifth subblock
    p_sub_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (int'(sub) < GRP_CNT));

    // R1: position within a subblock stays below L
    p_pos_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (pos < len));
endmodule

// File: rtl/cbuf_select.sv
module cbuf_select #(
    parameter int MAX_LEN = 24,
    parameter int MIN_LEN = 7,
    parameter int BLK_LEN = 60,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [LEN_W-1:0]   payload_len,
    input  logic [MAX_LEN-1:0] sub_a,
    input  logic [MAX_LEN-1:0] sub_b,
    input  logic [MAX_LEN-1:0] sub_c,
    input  logic [MAX_LEN-1:0] sub_d,
    input  logic [MAX_LEN-1:0] sub_e,
    output logic               bit_out,
    output logic               bit_valid,
    output logic               blk_done,
    output logic               len_err
);
    import cbuf_pkg::*;

    localparam int PTR_W = $clog2(BLK_LEN + 1);
    localparam int SUB_W = $clog2(GRP_CNT);

    sel_state_t state_q, state_d;

    logic [GRP_CNT-1:0][MAX_LEN-1:0] snap_q;
    logic [LEN_W-1:0] len_q;
    logic [PTR_W-1:0] kbuf_q;
    logic [PTR_W-1:0] out_cnt;
    logic [PTR_W-1:0] kbuf_in;
    logic             len_ok;
    logic             accept;
    logic             last_bit;
    logic [SUB_W-1:0] sub;
    logic [LEN_W-1:0] pos;
    logic [PTR_W-1:0] ptr;

    kbuf_lut #(
        .LEN_W   (LEN_W),
        .PTR_W   (PTR_W),
        .MIN_LEN (MIN_LEN),
        .MAX_LEN (MAX_LEN),
        .KB_LONG (BLK_LEN)
    ) u_lut (
        .len    (payload_len),
        .kbuf   (kbuf_in),
        .len_ok (len_ok)
    );

    assign accept   = (state_q == ST_IDLE) && start && len_ok;
    assign last_bit = (state_q == ST_EMIT) && (out_cnt == PTR_W'(BLK_LEN - 1));

    grp_addr #(
        .LEN_W (LEN_W),
        .PTR_W (PTR_W),
        .SUB_W (SUB_W)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .adv   (state_q == ST_EMIT),
        .len   (len_q),
        .kbuf  (kbuf_q),
        .sub   (sub),
        .pos   (pos),
        .ptr   (ptr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start && len_ok)  state_d = ST_EMIT;
                else if (start)       state_d = ST_REJECT;
            end
            ST_EMIT:   if (last_bit) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // capture and output counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q  <= '0;
            len_q   <= '0;
            kbuf_q  <= '0;
            out_cnt <= '0;
        end else if (accept) begin
            snap_q  <= {sub_e, sub_d, sub_c, sub_b, sub_a};
            len_q   <= payload_len;
            kbuf_q  <= kbuf_in;
            out_cnt <= '0;
        end else if (state_q == ST_EMIT) begin
            out_cnt <= out_cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        bit_valid = 1'b0;
        blk_done  = 1'b0;
        len_err   = 1'b0;
        bit_out   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_EMIT: begin
                bit_valid = 1'b1;
                bit_out   = snap_q[sub][pos];
            end
            ST_FINISH: blk_done = 1'b1;
            ST_REJECT: len_err  = 1'b1;
            default:   ;
        endcase
    end

    // R7/R8: at most one of the three strobes at a time
    p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bit_valid, blk_done, len_err}));

    // R7: done directly follows a valid bit
    p_done_after_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> $past(bit_valid));

    // R8: an error only ever answers a start request
    p_err_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> $past(start));

    // R3: never more than the block length of valid bits
    p_cnt_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> (int'(out_cnt) < BLK_LEN));

    // R6: the buffer in use is a prefix of the grouped sequence
    p_kbuf_fits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> (int'(kbuf_q) <= GRP_CNT * int'(len_q)));

    // R9: captured length is held for the whole block
    p_len_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && $past(bit_valid)) |-> $stable(len_q));
endmodule

// File: tb/tb_cbuf_select.sv
module tb_cbuf_select;
    localparam int ML = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [4:0]    payload_len = '0;
    logic [ML-1:0] sub_a = '0, sub_b = '0, sub_c = '0, sub_d = '0, sub_e = '0;
    logic          bit_out, bit_valid, blk_done, len_err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #2.5 clk = ~clk;

    cbuf_select dut (
        .clk(clk), .rst_n(rst_n), .start(start), .payload_len(payload_len),
        .sub_a(sub_a), .sub_b(sub_b), .sub_c(sub_c), .sub_d(sub_d), .sub_e(sub_e),
        .bit_out(bit_out), .bit_valid(bit_valid), .blk_done(blk_done), .len_err(len_err)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    function automatic int exp_kbuf(input int l);
        if (l <= 9) return 30;
        if (l == 10) return 50;
        if (l == 11) return 55;
        return 60;
    endfunction

    function automatic logic grp_bit(input int k, input int l,
        input logic [ML-1:0] a, b, c, d, e);
        int s = k / l;
        int p = k % l;
        case (s)
            0: return a[p];
            1: return b[p];
            2: return c[p];
            3: return d[p];
            default: return e[p];
        endcase
    endfunction

    task automatic fill_rand();
        rng = nxt(rng); sub_a = rng[ML-1:0];
        rng = nxt(rng); sub_b = rng[ML-1:0];
        rng = nxt(rng); sub_c = rng[ML-1:0];
        rng = nxt(rng); sub_d = rng[ML-1:0];
        rng = nxt(rng); sub_e = rng[ML-1:0];
    endtask

    // R1 R2 R3 R4 R5 R6 R7 R9: send one block, optionally disturbing inputs mid-block
    task automatic run_block(input int l, input bit disturb);
        logic [ML-1:0] a, b, c, d, e;
        int kb = exp_kbuf(l);
        fill_rand();
        a = sub_a; b = sub_b; c = sub_c; d = sub_d; e = sub_e;
        @(negedge clk);
        payload_len = 5'(l);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j < 60; j++) begin
            if (disturb && j == 5) begin
                sub_a = ~a; sub_b = ~b; sub_c = ~c; sub_d = ~d; sub_e = ~e;
                payload_len = 5'(l == 24 ? 7 : 24);
                start = 1'b1;
            end
            if (disturb && j == 6) start = 1'b0;
            chk($sformatf("R3 valid L=%0d j=%0d", l, j), bit_valid, 1'b1);
            chk($sformatf("R2 bit L=%0d j=%0d kbuf=%0d", l, j, kb), bit_out,
                grp_bit(j % kb, l, a, b, c, d, e));
            @(negedge clk);
        end
        chk($sformatf("R7 done L=%0d", l), blk_done, 1'b1);
        chk($sformatf("R7 valid low at done L=%0d", l), bit_valid, 1'b0);
        @(negedge clk);
        chk($sformatf("R7 done single L=%0d", l), blk_done, 1'b0);
        chk($sformatf("R9 no restart L=%0d", l), bit_valid, 1'b0);
    endtask

    // R8: illegal length
    task automatic run_bad(input int l);
        @(negedge clk);
        payload_len = 5'(l);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk($sformatf("R8 err L=%0d", l), len_err, 1'b1);
        chk($sformatf("R8 no valid L=%0d", l), bit_valid, 1'b0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk($sformatf("R8 err single L=%0d", l), len_err, 1'b0);
            chk($sformatf("R8 still no valid L=%0d", l), bit_valid, 1'b0);
            chk($sformatf("R8 no done L=%0d", l), blk_done, 1'b0);
        end
    endtask

    task automatic check_reset();
        @(negedge clk);
        chk("R10 valid", bit_valid, 1'b0);
        chk("R10 done", blk_done, 1'b0);
        chk("R10 err", len_err, 1'b0);
        chk("R10 bit", bit_out, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        check_reset();
        run_block(7, 1'b0);   // R4
        run_block(9, 1'b0);   // R4
        run_block(10, 1'b0);  // R5
        run_block(11, 1'b0);  // R5
        run_block(12, 1'b0);  // R6
        run_block(17, 1'b0);  // R1 across boundaries
        run_block(24, 1'b0);  // R6 upper end
        run_block(8, 1'b1);   // R9
        run_block(20, 1'b1);  // R9
        run_bad(6);
        run_bad(25);
        run_bad(0);
        run_bad(31);
        run_block(13, 1'b0);  // recovers after errors
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule